// File: doc/BRIEF.md
# Prefixed opcode fetch sequencer

This block is the tick-level front end of an 8-bit CPU with a 16-bit address space. It runs opcode fetch machine cycles and drives the bus strobes and the address one clock tick at a time. It recognises the two index prefixes (0xDD, 0xFD) and the extended prefix (0xED). For an indexed instruction that addresses memory, it inserts a fixed displacement cycle that forms the effective address. It then hands each finished opcode, with its table page, to an execution stage. Executing the instruction body is outside this block. After a dispatch the sequencer starts the next fetch on the following tick.

The register file is also outside this block, so HL, IX, IY and the I register are fixed parameter values. The sequencer owns PC, the refresh counter R, the effective address and WZ. The input `idx_sel` picks IX (0) or IY (1). It is sampled on the dispatch tick of the indexed fetch, and the prefix byte itself does not select the register. Storing an immediate byte to an indexed address (opcode 0x36 after an index prefix) is completed inside the sequencer. The displacement and the immediate are both read in the 8-tick displacement cycle. A 3-tick write cycle follows, and its last tick leads straight into the next fetch.

The outputs `mreq`, `rd`, `wr` and `rfsh` depend only on the current tick. A memory byte is taken from `din` at the clock edge that ends a read tick while `wait_req` is low. `wait_req` high at that edge repeats the tick.

Top module: `pfs_fetch_seq`

## Requirements
- R1: While reset is held, and on the first tick after it is released, the block shows fetch tick T1: `mreq`=1, `rd`=1, `addr`=PC_INIT, `wr`=0, `rfsh`=0, `disp_valid`=0, `ea`=0, `wz`=0.
- R2: An opcode fetch lasts 4 ticks when there is no wait. T1 and T2 drive `mreq`+`rd` with `addr`=PC. The opcode is taken at the end of T2 and PC is incremented. T3 is the refresh tick. T4 drives no strobe and shows the incremented PC.
- R3: On the refresh tick T3, only `mreq` and `rfsh` are driven, and `addr` = {I_VAL, R}. At the end of T3, R[6:0] increments modulo 128 and R[7] keeps its value. R starts at R_INIT.
- R4: At an unprefixed T4 (opcode not 0xDD, 0xFD or 0xED), `ea` is loaded with HL_VAL. On the next tick `disp_valid`=1 for exactly one tick, with `disp_op`=opcode and `disp_page`=0. The unprefixed 0x36 dispatches this way too.
- R5: A fetched 0xDD or 0xFD starts a second 4-tick fetch with the same tick roles. At its T4, `ea` is loaded with IY_VAL if `idx_sel`=1, otherwise with IX_VAL.
- R6: An indexed opcode that does not address memory dispatches at its T4. The next tick has `disp_valid`=1, `disp_page`=0, and the next fetch begins.
- R7: An indexed opcode that addresses memory runs an 8-tick displacement cycle. These opcodes are 0x34, 0x35, 0x36, 0x46, 0x4E, 0x56, 0x5E, 0x66, 0x6E, 0x7E, 0x70 to 0x75, 0x77, 0x86, 0x8E, 0x96, 0x9E, 0xA6, 0xAE, 0xB6 and 0xBE. In the cycle, T1 is idle and T2 reads at PC and increments PC. At the end of T3, `ea` becomes `ea` plus the sign-extended byte, and `wz` takes the same value. T4 to T8 are idle, and after T8 the opcode dispatches with page 0.
- R8: For indexed 0x36, T5 of the displacement cycle reads the immediate byte at PC and increments PC. After T8 comes a write cycle in which `addr`=`ea` on all three ticks. Only T2 drives `mreq`+`wr`, with `dout` equal to the immediate byte. The tick after write T3 is fetch T1, and no dispatch pulse is produced.
- R9: A fetched 0xED starts a second 4-tick fetch. Its T4 dispatches with `disp_page`=1 and leaves `ea` unchanged.
- R10: `wait_req`=1 repeats T2 of every fetch, the displacement read, the immediate read and the write, and the strobes and address stay the same. Idle ticks ignore `wait_req`, and so does T5 for any opcode other than 0x36.
- R11: At most one of `rd`, `wr` and `rfsh` is high at a time, and any of them implies `mreq`. Ticks with no strobe show PC on `addr`, except the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wait_req | input | 1 | Stretches the current memory tick while high |
| din | input | 8 | Data bus byte from memory |
| idx_sel | input | 1 | Index register choice for indexed fetch: 0 IX, 1 IY |
| mreq | output | 1 | Memory request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| rfsh | output | 1 | Refresh strobe |
| addr | output | AW | Address bus |
| dout | output | 8 | Write data (the immediate byte) |
| disp_valid | output | 1 | One-tick dispatch pulse |
| disp_op | output | 8 | Dispatched opcode |
| disp_page | output | 1 | Opcode table page: 0 main, 1 extended |
| ea | output | AW | Effective address |
| wz | output | AW | Internal WZ register |

## Verification
A wrong tick counter or state shows up at once as a strobe pattern that is off by one tick. A lost or doubled PC increment moves the address of the next read tick. A wrong displacement add, a mis-extended sign or a wrong index choice appears in `ea` and `wz` on the tick after T3, and again on `addr` during the write cycle of the immediate store. A refresh counter that disturbs bit 7 is seen on the first refresh address after R wraps. A mishandled wait either repeats a tick the bench does not expect or fails to repeat one, so every trace that follows is shifted.

// File: rtl/pfs_pkg.sv
// Shared definitions for the prefixed opcode fetch sequencer.
// Assumes byte-wide opcodes and a two-page opcode table (main, extended).
package pfs_pkg;

    localparam int BYTE_W = 8;

    // One value per clock tick of every machine cycle the sequencer runs.
    typedef enum logic [4:0] {
        S_F1, S_F2, S_F3, S_F4,            // plain opcode fetch
        S_X1, S_X2, S_X3, S_X4,            // fetch after an index prefix
        S_E1, S_E2, S_E3, S_E4,            // fetch after the extended prefix
        S_D1, S_D2, S_D3, S_D4,            // displacement cycle, first half
        S_D5, S_D6, S_D7, S_D8,            // displacement cycle, second half
        S_W1, S_W2, S_W3                   // immediate store write cycle
    } tick_t;

    localparam logic [7:0] OP_PFX_X  = 8'hDD;
    localparam logic [7:0] OP_PFX_Y  = 8'hFD;
    localparam logic [7:0] OP_PFX_ED = 8'hED;
    localparam logic [7:0] OP_ST_IMM = 8'h36;
    localparam logic [7:0] OP_HALT   = 8'h76;

    // True for either index prefix byte.
    function automatic logic is_index_pfx(input logic [7:0] op);
        return (op == OP_PFX_X) || (op == OP_PFX_Y);
    endfunction

    // True for opcodes whose operand is the memory byte at the pointer.
    function automatic logic needs_disp(input logic [7:0] op);
        logic ld_from, ld_to, alu_mem, step_mem;
        ld_from  = (op[7:6] == 2'b01) && (op[2:0] == 3'b110);
        ld_to    = (op[7:3] == 5'b01110);
        alu_mem  = (op[7:6] == 2'b10) && (op[2:0] == 3'b110);
        step_mem = (op[7:2] == 6'b001101) && (op[1:0] != 2'b11);
        return ((ld_from || ld_to) && (op != OP_HALT)) || alu_mem || step_mem;
    endfunction

endpackage

// File: rtl/pfs_ctrl.sv
// Tick sequencer: holds the current tick, decides the next one and the
// register update strobes. Assumes the opcode register is valid from T3
// of a fetch until the next fetch overwrites it.
module pfs_ctrl
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic [7:0] opcode,
    output tick_t      st,
    output logic       pc_inc,
    output logic       take_op,
    output logic       take_disp,
    output logic       take_imm,
    output logic       r_inc,
    output logic       load_hl,
    output logic       load_idx,
    output logic       add_disp,
    output logic       disp_fire,
    output logic       disp_ed
);

    tick_t nxt;
    logic  is_st;
    logic  rd_t2;

    // Update strobes derived from the current tick.
    always_comb begin
        is_st     = (opcode == OP_ST_IMM);
        rd_t2     = (st == S_F2) || (st == S_X2) || (st == S_E2) || (st == S_D2)
                  || ((st == S_D5) && is_st);
        pc_inc    = rd_t2 && !wait_req;
        take_op   = ((st == S_F2) || (st == S_X2) || (st == S_E2)) && !wait_req;
        take_disp = (st == S_D2) && !wait_req;
        take_imm  = (st == S_D5) && is_st && !wait_req;
        r_inc     = (st == S_F3) || (st == S_X3) || (st == S_E3);
        load_hl   = (st == S_F4);
        load_idx  = (st == S_X4);
        add_disp  = (st == S_D3);
        disp_ed   = (st == S_E4);
        disp_fire = ((st == S_F4) && !is_index_pfx(opcode) && (opcode != OP_PFX_ED))
                  || ((st == S_X4) && !needs_disp(opcode))
                  || (st == S_E4)
                  || ((st == S_D8) && !is_st);
    end

    // Next-tick selection, including wait stretching and prefix branches.
    always_comb begin
        nxt = st;
        unique case (st)
            S_F1: nxt = S_F2;
            S_F2: nxt = wait_req ? S_F2 : S_F3;
            S_F3: nxt = S_F4;
            S_F4: begin
                if (is_index_pfx(opcode))      nxt = S_X1;
                else if (opcode == OP_PFX_ED)  nxt = S_E1;
                else                           nxt = S_F1;
            end
            S_X1: nxt = S_X2;
            S_X2: nxt = wait_req ? S_X2 : S_X3;
            S_X3: nxt = S_X4;
            S_X4: nxt = needs_disp(opcode) ? S_D1 : S_F1;
            S_E1: nxt = S_E2;
            S_E2: nxt = wait_req ? S_E2 : S_E3;
            S_E3: nxt = S_E4;
            S_E4: nxt = S_F1;
            S_D1: nxt = S_D2;
            S_D2: nxt = wait_req ? S_D2 : S_D3;
            S_D3: nxt = S_D4;
            S_D4: nxt = S_D5;
            S_D5: nxt = (is_st && wait_req) ? S_D5 : S_D6;
            S_D6: nxt = S_D7;
            S_D7: nxt = S_D8;
            S_D8: nxt = is_st ? S_W1 : S_F1;
            S_W1: nxt = S_W2;
            S_W2: nxt = wait_req ? S_W2 : S_W3;
            S_W3: nxt = S_F1;
            default: nxt = S_F1;
        endcase
    end

    // Tick register with synchronous reset into fetch T1.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_F1;
        else        st <= nxt;
    end

    AST_ST_HELD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && ((st == S_F2) || (st == S_D2) || (st == S_W2))) |=> (st == $past(st))); // R10

endmodule

// File: rtl/pfs_regs.sv
// Sequencer-owned registers: PC, refresh counter, opcode, displacement
// and immediate latches, effective address, WZ and the dispatch outputs.
// Assumes HL, IX and IY are constants supplied as parameters.
module pfs_regs
    import pfs_pkg::*;
#(
    parameter int              AW      = 16,
    parameter logic [AW-1:0]   PC_INIT = '0,
    parameter logic [AW-1:0]   HL_VAL  = '0,
    parameter logic [AW-1:0]   IX_VAL  = '0,
    parameter logic [AW-1:0]   IY_VAL  = '0,
    parameter logic [7:0]      R_INIT  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    din,
    input  logic          idx_sel,
    input  tick_t         st,
    input  logic          pc_inc,
    input  logic          take_op,
    input  logic          take_disp,
    input  logic          take_imm,
    input  logic          r_inc,
    input  logic          load_hl,
    input  logic          load_idx,
    input  logic          add_disp,
    input  logic          disp_fire,
    input  logic          disp_ed,
    output logic [7:0]    opcode,
    output logic [AW-1:0] pc,
    output logic [7:0]    r,
    output logic [7:0]    imm,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wz,
    output logic          disp_valid,
    output logic [7:0]    disp_op,
    output logic          disp_page
);

    localparam int EXT_W = AW - BYTE_W;

    logic [7:0]    dbyte;
    logic [AW-1:0] ea_sum;

    // Pointer plus sign-extended displacement.
    always_comb ea_sum = ea + {{EXT_W{dbyte[7]}}, dbyte};

    // PC, refresh counter and byte latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= PC_INIT;
            r      <= R_INIT;
            opcode <= '0;
            dbyte  <= '0;
            imm    <= '0;
        end else begin
            if (pc_inc)    pc     <= pc + 1'b1;
            if (r_inc)     r      <= {r[7], r[6:0] + 7'd1};
            if (take_op)   opcode <= din;
            if (take_disp) dbyte  <= din;
            if (take_imm)  imm    <= din;
        end
    end

    // Effective address and WZ.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea <= '0;
            wz <= '0;
        end else if (load_hl) begin
            ea <= HL_VAL;
        end else if (load_idx) begin
            ea <= idx_sel ? IY_VAL : IX_VAL;
        end else if (add_disp) begin
            ea <= ea_sum;
            wz <= ea_sum;
        end
    end

    // One-tick dispatch pulse with opcode and page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_op    <= '0;
            disp_page  <= 1'b0;
        end else begin
            disp_valid <= disp_fire;
            if (disp_fire) begin
                disp_op   <= opcode;
                disp_page <= disp_ed;
            end
        end
    end

    AST_WZ_TRACKS_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_D4) |-> (wz == ea)); // R7

endmodule

// File: rtl/pfs_bus.sv
// Bus driver: maps the current tick to strobes, address and write data.
// Assumes outputs depend on the tick only, never directly on wait.
module pfs_bus
    import pfs_pkg::*;
#(
    parameter int AW = 16
) (
    input  tick_t         st,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] ir,
    input  logic [AW-1:0] ea,
    input  logic [7:0]    imm,
    output logic          mreq,
    output logic          rd,
    output logic          wr,
    output logic          rfsh,
    output logic [AW-1:0] addr,
    output logic [7:0]    dout
);

    // Strobe and address selection per tick.
    always_comb begin
        mreq = 1'b0;
        rd   = 1'b0;
        wr   = 1'b0;
        rfsh = 1'b0;
        addr = pc;
        dout = imm;
        unique case (st)
            S_F1, S_F2, S_X1, S_X2, S_E1, S_E2, S_D2: begin
                mreq = 1'b1;
                rd   = 1'b1;
            end
            S_F3, S_X3, S_E3: begin
                mreq = 1'b1;
                rfsh = 1'b1;
                addr = ir;
            end
            S_D5: begin
                if (opcode == OP_ST_IMM) begin
                    mreq = 1'b1;
                    rd   = 1'b1;
                end
            end
            S_W1, S_W3: addr = ea;
            S_W2: begin
                mreq = 1'b1;
                wr   = 1'b1;
                addr = ea;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pfs_fetch_seq.sv
// Top of the prefixed opcode fetch sequencer. Runs plain, index-prefixed
// and extended-prefixed fetches, the indexed displacement cycle and the
// immediate store write cycle. Assumes register file values are constants.
module pfs_fetch_seq
    import pfs_pkg::*;
#(
    parameter int              AW      = 16,
    parameter logic [AW-1:0]   PC_INIT = 16'h0000,
    parameter logic [AW-1:0]   HL_VAL  = 16'h4000,
    parameter logic [AW-1:0]   IX_VAL  = 16'h8000,
    parameter logic [AW-1:0]   IY_VAL  = 16'h9100,
    parameter logic [7:0]      I_VAL   = 8'h3C,
    parameter logic [7:0]      R_INIT  = 8'hFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wait_req,
    input  logic [7:0]    din,
    input  logic          idx_sel,
    output logic          mreq,
    output logic          rd,
    output logic          wr,
    output logic          rfsh,
    output logic [AW-1:0] addr,
    output logic [7:0]    dout,
    output logic          disp_valid,
    output logic [7:0]    disp_op,
    output logic          disp_page,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wz
);

    tick_t         st;
    logic          pc_inc, take_op, take_disp, take_imm, r_inc;
    logic          load_hl, load_idx, add_disp, disp_fire, disp_ed;
    logic [7:0]    opcode;
    logic [AW-1:0] pc;
    logic [7:0]    r;
    logic [7:0]    imm;
    logic [AW-1:0] ir;

    // Refresh address: interrupt page register over the refresh counter.
    always_comb ir = AW'({I_VAL, r});

    pfs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .opcode(opcode),
        .st(st), .pc_inc(pc_inc), .take_op(take_op), .take_disp(take_disp),
        .take_imm(take_imm), .r_inc(r_inc), .load_hl(load_hl),
        .load_idx(load_idx), .add_disp(add_disp), .disp_fire(disp_fire),
        .disp_ed(disp_ed)
    );

    pfs_regs #(
        .AW(AW), .PC_INIT(PC_INIT), .HL_VAL(HL_VAL), .IX_VAL(IX_VAL),
        .IY_VAL(IY_VAL), .R_INIT(R_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .din(din), .idx_sel(idx_sel), .st(st),
        .pc_inc(pc_inc), .take_op(take_op), .take_disp(take_disp),
        .take_imm(take_imm), .r_inc(r_inc), .load_hl(load_hl),
        .load_idx(load_idx), .add_disp(add_disp), .disp_fire(disp_fire),
        .disp_ed(disp_ed), .opcode(opcode), .pc(pc), .r(r), .imm(imm),
        .ea(ea), .wz(wz), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_page(disp_page)
    );

    pfs_bus #(.AW(AW)) u_bus (
        .st(st), .opcode(opcode), .pc(pc), .ir(ir), .ea(ea), .imm(imm),
        .mreq(mreq), .rd(rd), .wr(wr), .rfsh(rfsh), .addr(addr), .dout(dout)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd, wr, rfsh}) && (!(rd || wr || rfsh) || mreq)); // R11

    AST_RD_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wait_req) |=> (rd && $stable(addr))); // R10

    AST_WR_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wait_req) |=> (wr && $stable(addr) && $stable(dout))); // R10

    AST_DISP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid); // R4

    AST_WR_AT_EA: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (addr == ea)); // R8

endmodule

// File: tb/tb_pfs_fetch_seq.sv
`timescale 1ns/1ps
module tb_pfs_fetch_seq;

    localparam int         AW      = 16;
    localparam logic [15:0] PC_INIT = 16'h0000;
    localparam logic [15:0] HL_VAL  = 16'h4000;
    localparam logic [15:0] IX_VAL  = 16'h8000;
    localparam logic [15:0] IY_VAL  = 16'h9100;
    localparam logic [7:0]  I_VAL   = 8'h3C;
    localparam logic [7:0]  R_INIT  = 8'hFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 1'b0;
    logic idx_sel = 1'b0;
    logic [7:0] din;
    logic mreq, rd, wr, rfsh, disp_valid, disp_page;
    logic [15:0] addr, ea, wz;
    logic [7:0] dout, disp_op;

    logic [7:0] mem [256];
    assign din = mem[addr[7:0]];

    always #5 clk = ~clk;

    pfs_fetch_seq #(
        .AW(AW), .PC_INIT(PC_INIT), .HL_VAL(HL_VAL), .IX_VAL(IX_VAL),
        .IY_VAL(IY_VAL), .I_VAL(I_VAL), .R_INIT(R_INIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .din(din),
        .idx_sel(idx_sel), .mreq(mreq), .rd(rd), .wr(wr), .rfsh(rfsh),
        .addr(addr), .dout(dout), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_page(disp_page), .ea(ea), .wz(wz)
    );

    typedef struct packed {
        logic        w;
        logic        s;
        logic        mreq;
        logic        rd;
        logic        wr;
        logic        rfsh;
        logic [15:0] addr;
        logic [7:0]  dout;
        logic        dv;
        logic [7:0]  dop;
        logic        dpg;
        logic [15:0] ea;
        logic [15:0] wz;
    } rec_t;

    rec_t  q[$];
    string q_bus[$];
    string q_dsp[$];
    string q_ea[$];

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;

    int    m_pc, m_r, m_ea, m_wz;
    bit    m_sel;
    bit    p_dv;
    int    p_op;
    bit    p_pg;
    string p_tag = "R4";
    string e_tag = "R1";

    // Independent list of opcodes that take a displacement (R7).
    function automatic bit has_disp(input int op);
        case (op)
            'h34, 'h35, 'h36, 'h46, 'h4E, 'h56, 'h5E, 'h66, 'h6E, 'h7E,
            'h70, 'h71, 'h72, 'h73, 'h74, 'h75, 'h77,
            'h86, 'h8E, 'h96, 'h9E, 'hA6, 'hAE, 'hB6, 'hBE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input bit w, input bit mq, input bit r_, input bit w_,
                        input bit rf, input int a, input int d, input string tag);
        rec_t x;
        x.w = w; x.s = m_sel; x.mreq = mq; x.rd = r_; x.wr = w_; x.rfsh = rf;
        x.addr = 16'(a); x.dout = 8'(d);
        x.dv = p_dv; x.dop = 8'(p_op); x.dpg = p_pg;
        x.ea = 16'(m_ea); x.wz = 16'(m_wz);
        q.push_back(x); q_bus.push_back(tag); q_dsp.push_back(p_tag); q_ea.push_back(e_tag);
        p_dv = 0;
    endtask

    task automatic fetch(input int nw, input string tag, output int op);
        push(0, 1, 1, 0, 0, m_pc, 0, tag);
        repeat (nw) push(1, 1, 1, 0, 0, m_pc, 0, "R10");
        push(0, 1, 1, 0, 0, m_pc, 0, tag);
        op = int'(mem[m_pc & 255]);
        m_pc = (m_pc + 1) & 'hFFFF;
        push(0, 1, 0, 0, 1, (int'(I_VAL) << 8) | m_r, 0, "R3");
        m_r = (m_r & 'h80) | ((m_r + 1) & 'h7F);
        push(0, 0, 0, 0, 0, m_pc, 0, "R11");
    endtask

    task automatic dispatch(input int op, input bit pg, input string tag);
        p_dv = 1; p_op = op; p_pg = pg; p_tag = tag;
    endtask

    // Expected tick trace of one instruction's front-end part.
    task automatic instr(input bit sel, input int nw1, input int nw2,
                         input int nwd, input int nwi, input int nww);
        int op, op2, d, im;
        m_sel = sel;
        fetch(nw1, "R2", op);
        m_ea = HL_VAL; e_tag = "R4";
        if (op == 'hDD || op == 'hFD) begin
            fetch(nw2, "R5", op2);
            m_ea = sel ? IY_VAL : IX_VAL; e_tag = "R5";
            if (!has_disp(op2)) begin
                dispatch(op2, 0, "R6");
            end else begin
                push(0, 0, 0, 0, 0, m_pc, 0, "R7");
                repeat (nwd) push(1, 1, 1, 0, 0, m_pc, 0, "R10");
                push(0, 1, 1, 0, 0, m_pc, 0, "R7");
                d = int'(mem[m_pc & 255]);
                m_pc = (m_pc + 1) & 'hFFFF;
                push(0, 0, 0, 0, 0, m_pc, 0, "R7");
                if (d > 127) d = d - 256;
                m_ea = (m_ea + d) & 'hFFFF; m_wz = m_ea; e_tag = "R7";
                push(1, 0, 0, 0, 0, m_pc, 0, "R10");
                if (op2 == 'h36) begin
                    repeat (nwi) push(1, 1, 1, 0, 0, m_pc, 0, "R10");
                    push(0, 1, 1, 0, 0, m_pc, 0, "R8");
                    im = int'(mem[m_pc & 255]);
                    m_pc = (m_pc + 1) & 'hFFFF;
                    repeat (3) push(0, 0, 0, 0, 0, m_pc, 0, "R8");
                    push(0, 0, 0, 0, 0, m_ea, 0, "R8");
                    repeat (nww) push(1, 1, 0, 1, 0, m_ea, im, "R10");
                    push(0, 1, 0, 1, 0, m_ea, im, "R8");
                    push(0, 0, 0, 0, 0, m_ea, 0, "R8");
                end else begin
                    push(1, 0, 0, 0, 0, m_pc, 0, "R10");
                    repeat (3) push(0, 0, 0, 0, 0, m_pc, 0, "R7");
                    dispatch(op2, 0, "R7");
                end
            end
        end else if (op == 'hED) begin
            fetch(nw2, "R9", op2);
            dispatch(op2, 1, "R9");
        end else begin
            dispatch(op, 0, "R4");
        end
    endtask

    task automatic chk(input string tag, input int n, input string fld,
                       input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s tick %0d %s act=%h exp=%h", tag, n, fld, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
    endtask

    // Compare the outputs with record n, then drive its inputs.
    task automatic apply(input int n);
        rec_t x;
        x = q[n];
        vectors++;
        chk(q_bus[n], n, "mreq", int'(mreq), int'(x.mreq));
        chk(q_bus[n], n, "rd", int'(rd), int'(x.rd));
        chk(q_bus[n], n, "wr", int'(wr), int'(x.wr));
        chk(q_bus[n], n, "rfsh", int'(rfsh), int'(x.rfsh));
        chk(q_bus[n], n, "addr", int'(addr), int'(x.addr));
        if (x.wr) chk(q_bus[n], n, "dout", int'(dout), int'(x.dout));
        chk(q_dsp[n], n, "disp_valid", int'(disp_valid), int'(x.dv));
        if (x.dv) begin
            chk(q_dsp[n], n, "disp_op", int'(disp_op), int'(x.dop));
            chk(q_dsp[n], n, "disp_page", int'(disp_page), int'(x.dpg));
        end
        chk(q_ea[n], n, "ea", int'(ea), int'(x.ea));
        chk(q_ea[n], n, "wz", int'(wz), int'(x.wz));
        wait_req = x.w;
        idx_sel  = x.s;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem['h01] = 8'h7E;
        mem['h02] = 8'hDD; mem['h03] = 8'h7E; mem['h04] = 8'h05;
        mem['h05] = 8'hFD; mem['h06] = 8'h86; mem['h07] = 8'hF0;
        mem['h08] = 8'hDD; mem['h09] = 8'h36; mem['h0A] = 8'hFE; mem['h0B] = 8'h5A;
        mem['h0C] = 8'hED; mem['h0D] = 8'h44;
        mem['h0E] = 8'hDD; mem['h0F] = 8'h21;
        mem['h10] = 8'hFD; mem['h11] = 8'h09;
        mem['h12] = 8'h36;
        mem['h13] = 8'hFD; mem['h14] = 8'h34; mem['h15] = 8'h80;
        mem['h16] = 8'hDD; mem['h17] = 8'h35; mem['h18] = 8'h7F;
        mem['h19] = 8'hFD; mem['h1A] = 8'h46; mem['h1B] = 8'h10;

        m_pc = PC_INIT; m_r = R_INIT; m_ea = 0; m_wz = 0; m_sel = 0; p_dv = 0;
        instr(0, 0, 0, 0, 0, 0);   // R4 plain opcode
        instr(0, 2, 0, 0, 0, 0);   // R10 stretched fetch
        instr(0, 0, 0, 1, 0, 0);   // R7 IX + 5, stretched displacement read
        instr(1, 0, 1, 0, 0, 0);   // R7 IY - 16
        instr(0, 0, 0, 0, 1, 2);   // R8 immediate store to IX - 2
        instr(0, 0, 1, 0, 0, 0);   // R9 extended page
        instr(0, 0, 0, 0, 0, 0);   // R6 indexed, no memory operand
        instr(1, 0, 0, 0, 0, 0);   // R6 with IY
        instr(0, 0, 0, 0, 0, 0);   // R4 plain 0x36
        instr(1, 0, 0, 0, 0, 0);   // R7 displacement -128
        instr(0, 0, 0, 0, 0, 0);   // R7 displacement +127
        instr(0, 0, 0, 0, 0, 0);   // R5 selector overrides prefix byte
        instr(0, 0, 0, 0, 0, 0);
        instr(0, 0, 0, 0, 0, 0);

        // R1: reset state
        wait_req = 1'b1;
        repeat (3) @(negedge clk);
        vectors++;
        chk("R1", -1, "mreq", int'(mreq), 1);
        chk("R1", -1, "rd", int'(rd), 1);
        chk("R1", -1, "wr", int'(wr), 0);
        chk("R1", -1, "rfsh", int'(rfsh), 0);
        chk("R1", -1, "addr", int'(addr), int'(PC_INIT));
        chk("R1", -1, "disp_valid", int'(disp_valid), 0);
        chk("R1", -1, "ea", int'(ea), 0);
        chk("R1", -1, "wz", int'(wz), 0);
        rst_n = 1'b1;
        apply(0);
        for (int n = 1; n < q.size(); n++) begin
            @(negedge clk);
            apply(n);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", vectors, q.size());
            summary();
            $finish;
        end
    end

endmodule